// File: doc/BRIEF.md
# Raster Counter and Memory Slot Scheduler

This block produces the horizontal and vertical raster position of a video processor and divides every scanline into fixed video-memory access slots. Each slot lasts two horizontal counts. Every slot is handed to exactly one of three requesters: the background tile fetcher, the sprite fetcher, or a shared refresh/external port. The fetch engines watch the one-hot grant and use the memory only in the slot they are granted.

The line is 416 counts long, so it holds 208 slots, and a frame is 262 lines. The first 160 slots fall in the visible part of the line. They carry all 123 background fetches, with the 37 leftover visible slots spread evenly among them and given to sprites. The blanking part of the line gives its first 43 slots to sprites, for 80 sprite slots per line in total, and its last 5 slots to refresh/external access. The schedule is the same on every line, including lines in vertical blanking, so the fetchers work out their timing from the slot index alone.

Reset is asserted asynchronously and released through a two-stage synchronizer. Counting starts on the third rising clock edge after the reset input goes high.

Top module: `raster_slot_sched`

## Requirements
- R1: `hpos` advances by one on every clock after reset. It runs 0 to 415 and returns to 0 after 415.
- R2: `vpos` runs 0 to 261 and returns to 0 when it would pass 261.
- R3: `vpos` changes only on the clock edge where `hpos` goes from 415 to 0, and then it advances by one or wraps.
- R4: `slot_idx` equals `hpos` shifted right by one. `grant` is all zeros whenever `hpos` is odd.
- R5: Whenever `hpos` is even, exactly one bit of `grant` is set. The bit positions are: bit 0 background, bit 1 sprite, bit 2 refresh/external.
- R6: For slot s below 160, the background bit is granted exactly when floor((s+1)*123/160) > floor(s*123/160). Otherwise the sprite bit is granted. Slot 0 therefore goes to sprite.
- R7: Slots 160 to 202 grant sprite. Slots 203 to 207 grant refresh/external.
- R8: Over each full line, the grants total 123 background, 80 sprite and 5 refresh/external.
- R9: `active` is high exactly when `hpos` < 320 and `vpos` < 240.
- R10: While reset is held, `hpos` and `vpos` read 0. They stay 0 until the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpos | output | 9 | Horizontal count, 0..415 |
| vpos | output | 9 | Vertical count, 0..261 |
| slot_idx | output | 8 | Current memory slot, hpos/2 |
| active | output | 1 | Inside the visible region |
| grant | output | 3 | One-hot slot owner: bit0 background, bit1 sprite, bit2 refresh/external |

## Verification
The interleave accumulator is the only hidden state. If it drifts, the wrong requester appears on the grant in some visible slot well before the line ends, and the per-line totals at the end of that line show the error again. A fault in the counter wrap or the vertical enable shows at `hpos`/`vpos` on the very cycle it happens, because the bench compares both counters and all three grant bits against its own model on every clock over a whole frame and beyond. Every line total is also checked, so a fault that moves grants without changing the first slots is still caught within one line.

// File: rtl/raster_slot_pkg.sv
package raster_slot_pkg;
  typedef enum logic [1:0] {
    CL_BG  = 2'd0,
    CL_SPR = 2'd1,
    CL_REF = 2'd2
  } client_e;
  localparam int NUM_CLIENTS = 3;
endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int H_TOTAL = 416,
  parameter int V_TOTAL = 262,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_q,
  output logic [VW-1:0] v_q,
  output logic          line_end
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_d;
  logic [VW-1:0] v_d;
  logic          v_en;

  assign line_end = (h_q == H_LAST);
  assign v_en     = line_end;

  always_comb begin
    h_d = line_end ? '0 : h_q + 1'b1;
    v_d = v_q;
    if (v_en) v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      if (v_en) v_q <= v_d;
    end
  end

  // R1: horizontal range and wrap
  a_r1_h_range: assert property (@(posedge clk) disable iff (!rst_n) h_q <= H_LAST);
  a_r1_h_wrap:  assert property (@(posedge clk) disable iff (!rst_n) (h_q == H_LAST) |=> (h_q == '0));
  // R2: vertical range
  a_r2_v_range: assert property (@(posedge clk) disable iff (!rst_n) v_q <= V_LAST);
  // R3: vertical count moves only across a line boundary
  a_r3_v_hold:  assert property (@(posedge clk) disable iff (!rst_n) (h_q != '0) |-> $stable(v_q));
endmodule

// File: rtl/slot_interleaver.sv
module slot_interleaver #(
  parameter int ACTIVE_SLOTS = 160,
  parameter int BG_SLOTS     = 123,
  parameter int SW           = 8,
  localparam int AW = $clog2(ACTIVE_SLOTS + BG_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slot,
  input  logic          slot_end,
  input  logic          line_end,
  output logic          bg_pick
);
  localparam logic [AW-1:0] ACT_W = AW'(ACTIVE_SLOTS);
  localparam logic [AW-1:0] BG_W  = AW'(BG_SLOTS);
  localparam logic [SW-1:0] ACT_S = SW'(ACTIVE_SLOTS);

  logic [AW-1:0] acc_q, acc_d, sum;
  logic          acc_en;

  assign sum     = acc_q + BG_W;
  assign bg_pick = (sum >= ACT_W);
  assign acc_en  = slot_end && (line_end || slot < ACT_S);

  always_comb begin
    if (line_end)     acc_d = '0;
    else if (bg_pick) acc_d = sum - ACT_W;
    else              acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // R6: the remainder always stays below the visible slot count
  a_r6_acc_bound: assert property (@(posedge clk) disable iff (!rst_n) acc_q < ACT_W);
  // R6: the remainder is back at zero when a new line starts
  a_r6_line_zero: assert property (@(posedge clk) disable iff (!rst_n) line_end |=> (acc_q == '0));
endmodule

// File: rtl/grant_decoder.sv
module grant_decoder
  import raster_slot_pkg::*;
#(
  parameter int ACTIVE_SLOTS = 160,
  parameter int SLOT_TOTAL   = 208,
  parameter int REF_SLOTS    = 5,
  parameter int SW           = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SW-1:0]          slot,
  input  logic                   slot_first,
  input  logic                   bg_pick,
  output logic [NUM_CLIENTS-1:0] grant
);
  localparam logic [SW-1:0] ACT_S = SW'(ACTIVE_SLOTS);
  localparam logic [SW-1:0] REF_S = SW'(SLOT_TOTAL - REF_SLOTS);

  client_e owner;

  always_comb begin
    if (slot < ACT_S)      owner = bg_pick ? CL_BG : CL_SPR;
    else if (slot < REF_S) owner = CL_SPR;
    else                   owner = CL_REF;
    grant = '0;
    if (slot_first) grant[owner] = 1'b1;
  end

  // R4: no grant in the second half of a slot
  a_r4_odd_quiet: assert property (@(posedge clk) disable iff (!rst_n) !slot_first |-> (grant == '0));
  // R5: exactly one owner at the start of a slot
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n) slot_first |-> ($countones(grant) == 1));
  // R7: refresh only in the tail of the line, background only in visible slots
  a_r7_ref_tail:  assert property (@(posedge clk) disable iff (!rst_n) grant[CL_REF] |-> (slot >= REF_S));
  a_r7_bg_vis:    assert property (@(posedge clk) disable iff (!rst_n) grant[CL_BG] |-> (slot < ACT_S));
endmodule

// File: rtl/raster_slot_sched.sv
module raster_slot_sched
  import raster_slot_pkg::*;
#(
  parameter int H_TOTAL      = 416,
  parameter int V_TOTAL      = 262,
  parameter int V_VISIBLE    = 240,
  parameter int ACTIVE_SLOTS = 160,
  parameter int BG_SLOTS     = 123,
  parameter int REF_SLOTS    = 5,
  localparam int HW         = $clog2(H_TOTAL),
  localparam int VW         = $clog2(V_TOTAL),
  localparam int SLOT_TOTAL = H_TOTAL / 2,
  localparam int SW         = $clog2(SLOT_TOTAL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [HW-1:0]          hpos,
  output logic [VW-1:0]          vpos,
  output logic [SW-1:0]          slot_idx,
  output logic                   active,
  output logic [NUM_CLIENTS-1:0] grant
);
  localparam logic [HW-1:0] H_VIS = HW'(2 * ACTIVE_SLOTS);
  localparam logic [VW-1:0] V_VIS = VW'(V_VISIBLE);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       line_end;
  logic       bg_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  raster_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .h_q(hpos), .v_q(vpos), .line_end(line_end)
  );

  assign slot_idx = hpos[HW-1:1];
  assign active   = (hpos < H_VIS) && (vpos < V_VIS);

  slot_interleaver #(.ACTIVE_SLOTS(ACTIVE_SLOTS), .BG_SLOTS(BG_SLOTS), .SW(SW)) u_mix (
    .clk(clk), .rst_n(rst_n_i), .slot(slot_idx), .slot_end(hpos[0]),
    .line_end(line_end), .bg_pick(bg_pick)
  );

  grant_decoder #(.ACTIVE_SLOTS(ACTIVE_SLOTS), .SLOT_TOTAL(SLOT_TOTAL),
                  .REF_SLOTS(REF_SLOTS), .SW(SW)) u_dec (
    .clk(clk), .rst_n(rst_n_i), .slot(slot_idx), .slot_first(!hpos[0]),
    .bg_pick(bg_pick), .grant(grant)
  );

  // R9: visible flag never set in horizontal blanking
  a_r9_hblank: assert property (@(posedge clk) disable iff (!rst_n_i) (hpos >= H_VIS) |-> !active);
endmodule

// File: tb/raster_slot_sched_test.sv
`timescale 1ns/1ps
module raster_slot_sched_test;
  logic       clk;
  logic       rst_n;
  logic [8:0] hpos, vpos;
  logic [7:0] slot_idx;
  logic       active;
  logic [2:0] grant;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit done = 0;

  int mh = 0, mv = 0, edges = 0;
  int cnt_bg = 0, cnt_spr = 0, cnt_ref = 0;
  bit counting = 0;
  bit saw_v_last = 0, saw_v_wrap = 0;

  raster_slot_sched uut (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .slot_idx(slot_idx), .active(active), .grant(grant)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference: two sync stages, then free-running counters
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges = 0; mh = 0; mv = 0;
    end else begin
      if (edges >= 2) begin
        if (mh == 415) begin
          mh = 0;
          mv = (mv == 261) ? 0 : mv + 1;
        end else mh = mh + 1;
      end
      if (edges < 2) edges = edges + 1;
    end
  end

  function automatic logic [2:0] exp_grant(int h);
    int s;
    if (h % 2 == 1) return 3'b000;
    s = h / 2;
    if (s < 160) return (((s + 1) * 123) / 160 > (s * 123) / 160) ? 3'b001 : 3'b010;
    if (s < 203) return 3'b010;
    return 3'b100;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", req, act, exp, mh, mv);
    end
  endtask

  always @(negedge clk) if (running) begin
    logic [2:0] eg;
    eg = exp_grant(mh);
    chk(hpos == mh, "R1 hpos", hpos, mh);
    chk(vpos == mv, "R2/R3 vpos", vpos, mv);
    chk(slot_idx == mh / 2, "R4 slot_idx", slot_idx, mh / 2);
    if (mh % 2 == 1) chk(grant == 3'b000, "R4 odd grant", grant, 0);
    else chk($countones(grant) == 1, "R5 one-hot", grant, eg);
    if (mh / 2 < 160) chk(grant == eg, "R6 interleave", grant, eg);
    else chk(grant == eg, "R7 blanking slots", grant, eg);
    chk(active == (mh < 320 && mv < 240), "R9 active", active, (mh < 320 && mv < 240));
    if (mv == 261) saw_v_last = 1;
    if (saw_v_last && mv == 0 && vpos == 0) saw_v_wrap = 1;
    if (mh == 0) begin
      counting = 1; cnt_bg = 0; cnt_spr = 0; cnt_ref = 0;
    end
    if (counting) begin
      cnt_bg  += grant[0];
      cnt_spr += grant[1];
      cnt_ref += grant[2];
      if (mh == 415) begin
        chk(cnt_bg == 123, "R8 background total", cnt_bg, 123);
        chk(cnt_spr == 80, "R8 sprite total", cnt_spr, 80);
        chk(cnt_ref == 5, "R8 refresh total", cnt_ref, 5);
      end
    end
  end

  initial begin
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(hpos == 0, "R10 reset hpos", hpos, 0);
    chk(vpos == 0, "R10 reset vpos", vpos, 0);
    rst_n = 1;
    @(negedge clk);
    chk(hpos == 0, "R10 hold after release 1", hpos, 0);
    @(negedge clk);
    chk(hpos == 0, "R10 hold after release 2", hpos, 0);
    @(negedge clk);
    chk(hpos == 1, "R10 first count", hpos, 1);
    running = 1;
    repeat (110000) @(negedge clk);
    running = 0;
    chk(saw_v_wrap, "R2 frame wrap seen", saw_v_wrap, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule